// File: doc/BRIEF.md
# Prescaled Pulse Width Modulator

This block produces one pulse width modulated output from four control inputs. The inputs are a prescaler setting, a period value, a duty value and a full-duty override bit. A prescaler turns the input clock into an enable tick. All period counting advances on that tick. Each output period lasts the period value plus one ticks. The output is high at the start of each period and falls once the count within the period reaches the duty value.

The block copies the control inputs into an active set only at the end of a period, so changing the inputs never cuts a pulse short. Some settings give a fixed level instead of a waveform. A zero duty value without the override holds the output low. A zero period value, the override bit, or a duty value larger than the period hold the output high.

Top module: `pwm_gen`

## Requirements
- R1: One output period lasts (period value + 1) prescaled ticks; a period value of 10 gives 11 ticks.
- R2: Each period starts with the output high; it stays high for duty-value ticks and is low for the remaining ticks of the period (period 10, duty 6: 6 high, 5 low).
- R3: The prescaler produces one enable tick every (prescaler setting + 1) input clocks; a setting of 0 gives a tick on every clock.
- R4: A period value of 0 holds the output high with no toggling, unless R6 applies.
- R5: When the full-duty bit is 1, the output is held high for the whole period, whatever the duty value is.
- R6: When the full-duty bit is 0 and the duty value is 0, the output is held low, whatever the period value is.
- R7: A duty value greater than or equal to (period value + 1) gives a constant-high output.
- R8: Changes to the period, duty and full-duty inputs take effect only at the next period boundary; a period already in progress finishes with the old settings.
- R9: Synchronous active-low reset sets the active period to 4, the active duty and full-duty bit to 0, and the output low. The first boundary after reset is reached 5 ticks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous reset, active low |
| presc_cfg | input | PRESC_W (6) | Prescaler setting; tick every presc_cfg+1 clocks |
| period_cfg | input | PERIOD_W (10) | Period value; period is period_cfg+1 ticks |
| duty_cfg | input | PERIOD_W (10) | Number of high ticks per period |
| full_duty_cfg | input | 1 | Forces the output high for the whole period |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its default widths: a 6-bit prescaler and 10-bit period and duty values. It uses a prescaler of 0, where one tick equals one clock, and a prescaler of 2. With these two settings it can count the high and low runs exactly and see how the prescaler stretches each run. Small period values, 0 to 10, bring every fixed-level rule within a few dozen cycles. The same is true of the reset period of 4 and of a duty change made partway through a period.

// File: rtl/pwm_pkg.sv
// Shared defaults for the pulse width modulator.
// Assumes: consumers take these as parameter defaults only.
package pwm_pkg;
    localparam int PWM_PRESC_W_DEF    = 6;
    localparam int PWM_PERIOD_W_DEF   = 10;
    localparam int PWM_PERIOD_RST_DEF = 4;
endpackage

// File: rtl/pwm_prescaler.sv
// Prescaler: raises tick for one clock every presc+1 clocks.
// Assumes: presc may change at any time; if it drops below the running
// count, the next clock produces a tick and the count restarts.
module pwm_prescaler #(
    parameter int PRESC_W = pwm_pkg::PWM_PRESC_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc,
    output logic               tick
);
    logic [PRESC_W-1:0] div_q;

    // Tick when the divider has reached the setting.
    always_comb tick = (div_q >= presc);

    // Divider: restart on tick, otherwise count up.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    // R3: with a nonzero setting, ticks never fall on adjacent clocks.
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && presc != '0) |=> (!tick || presc == '0));
endmodule

// File: rtl/pwm_period_counter.sv
// Period counter: counts ticks 0..active period, then wraps at the boundary.
// At the boundary it loads the control inputs into the active set.
// Assumes: tick is a one-clock enable from the prescaler.
module pwm_period_counter #(
    parameter int PERIOD_W   = pwm_pkg::PWM_PERIOD_W_DEF,
    parameter int PERIOD_RST = pwm_pkg::PWM_PERIOD_RST_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] period_in,
    input  logic [PERIOD_W-1:0] duty_in,
    input  logic                full_in,
    output logic [PERIOD_W-1:0] cnt,
    output logic [PERIOD_W-1:0] act_period,
    output logic [PERIOD_W-1:0] act_duty,
    output logic                act_full,
    output logic                boundary
);
    // End of period: last tick of the active period.
    always_comb boundary = tick && (cnt == act_period);

    // Count ticks; at the boundary wrap and take the new settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            act_period <= PERIOD_W'(PERIOD_RST);
            act_duty   <= '0;
            act_full   <= 1'b0;
        end else if (boundary) begin
            cnt        <= '0;
            act_period <= period_in;
            act_duty   <= duty_in;
            act_full   <= full_in;
        end else if (tick) begin
            cnt        <= cnt + 1'b1;
        end
    end

    // R1: the count never passes the active period.
    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_period);

    // R8: active settings only change right after a boundary tick.
    a_r8_load_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        ({act_period, act_duty, act_full} != $past({act_period, act_duty, act_full}))
        |-> $past(tick && cnt == act_period));
endmodule

// File: rtl/pwm_wave.sv
// Output stage: turns the period count and the active settings into the level.
// Assumes: cnt never exceeds act_period (guaranteed by the counter).
module pwm_wave #(
    parameter int PERIOD_W = pwm_pkg::PWM_PERIOD_W_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PERIOD_W-1:0] cnt,
    input  logic [PERIOD_W-1:0] act_period,
    input  logic [PERIOD_W-1:0] act_duty,
    input  logic                act_full,
    output logic                level
);
    // Fixed levels first, with zero duty taking priority; otherwise compare.
    always_comb begin
        if (!act_full && act_duty == '0)           level = 1'b0;
        else if (act_full || act_period == '0)     level = 1'b1;
        else                                       level = (cnt < act_duty);
    end

    // R6: zero duty without override keeps the line low.
    a_r6_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_full && act_duty == '0) |-> !level);
endmodule

// File: rtl/pwm_gen.sv
// Top: prescaled pulse width modulator with full-duty override.
// Assumes: control inputs are synchronous to clk; they are sampled at
// the period boundary only.
module pwm_gen #(
    parameter int PRESC_W    = pwm_pkg::PWM_PRESC_W_DEF,
    parameter int PERIOD_W   = pwm_pkg::PWM_PERIOD_W_DEF,
    parameter int PERIOD_RST = pwm_pkg::PWM_PERIOD_RST_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PRESC_W-1:0]  presc_cfg,
    input  logic [PERIOD_W-1:0] period_cfg,
    input  logic [PERIOD_W-1:0] duty_cfg,
    input  logic                full_duty_cfg,
    output logic                pwm_out
);
    logic                tick;
    logic                boundary;
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] act_period;
    logic [PERIOD_W-1:0] act_duty;
    logic                act_full;

    pwm_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .presc (presc_cfg),
        .tick  (tick)
    );

    pwm_period_counter #(.PERIOD_W(PERIOD_W), .PERIOD_RST(PERIOD_RST)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .period_in  (period_cfg),
        .duty_in    (duty_cfg),
        .full_in    (full_duty_cfg),
        .cnt        (cnt),
        .act_period (act_period),
        .act_duty   (act_duty),
        .act_full   (act_full),
        .boundary   (boundary)
    );

    pwm_wave #(.PERIOD_W(PERIOD_W)) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt        (cnt),
        .act_period (act_period),
        .act_duty   (act_duty),
        .act_full   (act_full),
        .level      (pwm_out)
    );

    // R2: a period loaded with a nonzero duty or the override begins high.
    a_r2_period_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (full_duty_cfg || duty_cfg != '0)) |=> pwm_out);
endmodule

// File: tb/tb_pwm_gen.sv
`timescale 1ns/1ps
// Directed bench for pwm_gen: one task per scenario, each checking itself.
module tb_pwm_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] presc_cfg = '0;
    logic [9:0] period_cfg = '0;
    logic [9:0] duty_cfg = '0;
    logic       full_duty_cfg = 1'b0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_gen dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .presc_cfg     (presc_cfg),
        .period_cfg    (period_cfg),
        .duty_cfg      (duty_cfg),
        .full_duty_cfg (full_duty_cfg),
        .pwm_out       (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait until a sample shows a rising output; ok=0 on timeout.
    task automatic wait_rise(output bit ok);
        logic prev;
        ok = 1'b0;
        @(negedge clk);
        prev = pwm_out;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!prev && pwm_out) begin ok = 1'b1; break; end
            prev = pwm_out;
        end
    endtask

    // Count samples at the current level, including the present one.
    task automatic run_len(input logic lvl, output int n);
        n = 1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (pwm_out !== lvl) break;
            n++;
        end
    endtask

    task automatic apply(input int p, input int per, input int d, input bit f);
        presc_cfg = 6'(p); period_cfg = 10'(per); duty_cfg = 10'(d); full_duty_cfg = f;
    endtask

    // Measure one high run and the following low run after the next rise.
    task automatic measure(input string req, input int exp_hi, input int exp_lo);
        bit ok; int hi; int lo;
        wait_rise(ok);
        check({req, " rise seen"}, int'(ok), 1);
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check({req, " high run"}, hi, exp_hi);
        check({req, " low run"}, lo, exp_lo);
    endtask

    // Let settings settle, then require a constant level for 40 samples.
    task automatic hold_level(input string req, input logic lvl);
        int bad = 0;
        repeat (60) @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (pwm_out !== lvl) bad++;
        end
        check(req, bad, 0);
    endtask

    // R9: reset state, then first boundary after reset period 4 (5 ticks).
    task automatic t_reset();
        int lows = 0;
        apply(0, 10, 1, 1'b0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9 output low in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pwm_out) break;
            lows++;
        end
        check("R9 low samples before first boundary", lows, 4);
    endtask

    // R1 R2: period 10 duty 6 at prescaler 0.
    task automatic t_basic();
        apply(0, 10, 6, 1'b0);
        measure("R1 R2 per10 duty6", 6, 5);
        apply(0, 4, 1, 1'b0);
        measure("R1 R2 per4 duty1", 1, 4);
    endtask

    // R3: prescaler 2 stretches every tick to 3 clocks.
    task automatic t_presc();
        apply(2, 3, 2, 1'b0);
        measure("R3 presc2 per3 duty2", 6, 6);
        apply(0, 10, 6, 1'b0);
        measure("R3 presc0 restore", 6, 5);
    endtask

    // R8: duty change in the middle of a high run waits for the boundary.
    task automatic t_midchange();
        bit ok; int hi; int lo;
        apply(0, 10, 6, 1'b0);
        measure("R8 setup", 6, 5);
        wait_rise(ok);
        check("R8 rise seen", int'(ok), 1);
        hi = 1;
        repeat (2) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        duty_cfg = 10'd2;
        run_len(1'b1, lo);
        hi = hi + lo - 1;
        run_len(1'b0, lo);
        check("R8 current period keeps old high", hi, 6);
        check("R8 current period keeps old low", lo, 5);
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check("R8 next period uses new high", hi, 2);
        check("R8 next period uses new low", lo, 9);
    endtask

    // R4 R5 R6 R7: fixed-level settings.
    task automatic t_fixed();
        apply(0, 0, 3, 1'b0);
        hold_level("R4 period 0 holds high", 1'b1);
        apply(0, 5, 1, 1'b1);
        hold_level("R5 full-duty holds high", 1'b1);
        apply(0, 0, 0, 1'b1);
        hold_level("R5 full-duty with period 0 duty 0 high", 1'b1);
        apply(0, 0, 0, 1'b0);
        hold_level("R6 period 0 duty 0 holds low", 1'b0);
        apply(0, 7, 0, 1'b0);
        hold_level("R6 period 7 duty 0 holds low", 1'b0);
        apply(0, 9, 12, 1'b0);
        hold_level("R7 duty above period holds high", 1'b1);
        apply(0, 9, 10, 1'b0);
        hold_level("R7 duty equal period+1 holds high", 1'b1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_presc();
        t_midchange();
        t_fixed();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule